// File: doc/BRIEF.md
# Pull Bias Sequencer

This block holds the bias setting (pull-up, pull-down or none) of every pin in a bank of general-purpose pads. Software never writes a pin's bias directly. It loads a two-bit bias code into one shared control register. After a settle time it writes a per-bank strobe register with a one in the position of each pin it wants to change. Each pin whose strobe bit goes from zero to one captures the shared code. The pin keeps that setting after the strobe is cleared.

A settle counter restarts on every control write. It shows the code as busy until the required number of clock cycles has elapsed. A strobe write made while the counter is still busy is carried out anyway, but it sets a sticky flag so that software can detect that it broke the sequence. The per-pin bias state drives two one-hot pad outputs per pin and cannot be read back through the register port.

Top module: `pull_bias_sequencer`

## Requirements
- R1: A write to the control offset (0x94) loads bits [1:0] as the bias code, and all other write bits except bit 31 are ignored. A read of 0x94 returns the code in [1:0], the busy flag in bit 8, the early-strobe flag in bit 9, and zero elsewhere.
- R2: Codes are 00 = none, 01 = pull-down, 10 = pull-up. A pin captures the current code at the clock edge on which its strobe bit is written from 0 to 1. Pin 32*b+j uses bit j of the strobe register at 0x98 + 4*b.
- R3: A pin keeps its captured bias after its strobe bit returns to 0, and no pin output changes in a cycle without a strobe write.
- R4: Code 11 is reserved, and a strobe rising edge while it is loaded leaves the pin unchanged.
- R5: The busy flag (bit 8 and the `settle_busy` port) is high for exactly 150 cycles after the edge that takes a control write. Each new control write restarts the count.
- R6: A strobe write taken while busy still captures the code and sets the sticky early-strobe flag.
- R7: The early-strobe flag stays set until a control write with bit 31 set clears it. A control write with bit 31 clear leaves the flag as it is.
- R8: After reset every pin has no bias, both strobe registers read zero, the code is 00, and the block is not busy.
- R9: A strobe register reads back its stored bits. Bits of the last bank above the final pin (bits 31:22 of 0x9C) are not stored and read as zero.
- R10: Rewriting a strobe bit that is already 1 is not a rising edge, so the pin keeps its bias even when the code has since changed.
- R11: Reads of any other offset return zero, so the per-pin bias cannot be read through the port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| settle_busy | output | 1 | High while the loaded code is still settling |
| pull_up_en | output | 54 | Per-pin pull-up enable to the pads |
| pull_dn_en | output | 54 | Per-pin pull-down enable to the pads |

## Verification
The bench targets strobe edge detection. It rewrites an already-set strobe bit after changing the code, which a design capturing on level rather than on a rising edge would wrongly apply. It strobes with the reserved code, which a design without the guard would turn into an illegal bias. It probes the busy window at its last cycle, which an off-by-one counter would end one cycle early or late. It issues a strobe one cycle after a control write and checks that the early flag latches and survives a control write whose bit 31 is clear. It writes ones above pin 53 in the second strobe register, which would show up on readback if the unused bits were stored.

// File: rtl/pull_seq_pkg.sv
package pull_seq_pkg;
   typedef enum logic [1:0] {
      PULL_NONE = 2'b00,
      PULL_DOWN = 2'b01,
      PULL_UP   = 2'b10,
      PULL_RSVD = 2'b11
   } pull_code_e;
endpackage

// File: rtl/pull_ctrl_reg.sv
module pull_ctrl_reg
   import pull_seq_pkg::*;
#(
   parameter int unsigned SETTLE_CYCLES = 150,
   localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctrl_wr,
   input  logic [1:0] ctrl_code,
   input  logic       ctrl_clr_early,
   input  logic       strobe_wr,
   output pull_code_e code_q,
   output logic       busy,
   output logic       early_q
);
   logic [CNT_W-1:0] cnt_q;

   assign busy = (cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q  <= PULL_NONE;
         cnt_q   <= '0;
         early_q <= 1'b0;
      end else if (ctrl_wr) begin
         code_q <= pull_code_e'(ctrl_code);
         cnt_q  <= CNT_W'(SETTLE_CYCLES);
         if (ctrl_clr_early) early_q <= 1'b0;
      end else begin
         if (busy) cnt_q <= cnt_q - CNT_W'(1);
         if (strobe_wr && busy) early_q <= 1'b1;
      end
   end
endmodule

// File: rtl/pull_bank_strobe.sv
module pull_bank_strobe #(
   parameter int unsigned LIVE_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [LIVE_W-1:0] wdata,
   output logic [LIVE_W-1:0] strobe_q,
   output logic [LIVE_W-1:0] rise
);
   assign rise = wr ? (wdata & ~strobe_q) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  strobe_q <= '0;
      else if (wr) strobe_q <= wdata;
   end
endmodule

// File: rtl/pull_pin_cell.sv
module pull_pin_cell
   import pull_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       capture,
   input  pull_code_e code,
   output pull_code_e state_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= PULL_NONE;
      else if (capture && code != PULL_RSVD)
         state_q <= code;
   end
endmodule

// File: rtl/pull_bias_sequencer.sv
module pull_bias_sequencer
   import pull_seq_pkg::*;
#(
   parameter int unsigned NUM_PINS      = 54,
   parameter int unsigned BANK_W        = 32,
   parameter int unsigned SETTLE_CYCLES = 150,
   parameter int unsigned ADDR_W        = 8,
   parameter logic [ADDR_W-1:0] CTRL_OFFSET = 8'h94,
   parameter logic [ADDR_W-1:0] STRB_OFFSET = 8'h98
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   output logic                settle_busy,
   output logic [NUM_PINS-1:0] pull_up_en,
   output logic [NUM_PINS-1:0] pull_dn_en
);
   localparam int unsigned NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;

   if (BANK_W < 1 || BANK_W > 32) begin : g_bad_bank
      $error("BANK_W must lie in 1..32");
   end
   if (NUM_PINS < 1) begin : g_bad_pins
      $error("NUM_PINS must be at least 1");
   end
   if (SETTLE_CYCLES < 1) begin : g_bad_settle
      $error("SETTLE_CYCLES must be at least 1");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   pull_code_e            code_q;
   logic                  early_q;
   logic                  ctrl_sel;
   logic [NUM_BANKS-1:0]  bank_sel;
   logic [NUM_BANKS-1:0]  bank_hit;
   logic [NUM_PINS-1:0]   strobe_all;
   logic [NUM_PINS-1:0]   rise_all;
   logic [31:0]           bank_rd [NUM_BANKS];
   pull_code_e            pin_state [NUM_PINS];

   assign ctrl_sel = (reg_addr == CTRL_OFFSET);

   pull_ctrl_reg #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .ctrl_wr        (reg_wr && ctrl_sel),
      .ctrl_code      (reg_wdata[1:0]),
      .ctrl_clr_early (reg_wdata[31]),
      .strobe_wr      (|bank_hit),
      .code_q         (code_q),
      .busy           (settle_busy),
      .early_q        (early_q)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int unsigned LEFT = NUM_PINS - b * BANK_W;
      localparam int unsigned LIVE = (LEFT > BANK_W) ? BANK_W : LEFT;
      localparam logic [ADDR_W-1:0] BANK_ADDR = STRB_OFFSET + ADDR_W'(4 * b);

      assign bank_sel[b] = (reg_addr == BANK_ADDR);
      assign bank_hit[b] = reg_wr && bank_sel[b];

      pull_bank_strobe #(.LIVE_W(LIVE)) u_strobe (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr       (bank_hit[b]),
         .wdata    (reg_wdata[LIVE-1:0]),
         .strobe_q (strobe_all[b*BANK_W +: LIVE]),
         .rise     (rise_all[b*BANK_W +: LIVE])
      );

      assign bank_rd[b] = bank_sel[b] ? 32'(strobe_all[b*BANK_W +: LIVE]) : 32'h0;
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      pull_pin_cell u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .capture (rise_all[p]),
         .code    (code_q),
         .state_q (pin_state[p])
      );
      assign pull_up_en[p] = (pin_state[p] == PULL_UP);
      assign pull_dn_en[p] = (pin_state[p] == PULL_DOWN);
   end

   always_comb begin
      reg_rdata = '0;
      if (ctrl_sel) begin
         reg_rdata[1:0] = code_q;
         reg_rdata[8]   = settle_busy;
         reg_rdata[9]   = early_q;
      end
      for (int b = 0; b < NUM_BANKS; b++) reg_rdata = reg_rdata | bank_rd[b];
   end
endmodule

// File: rtl/pull_bias_sequencer_chk.sv
module pull_bias_sequencer_chk #(
   parameter int unsigned NUM_PINS      = 54,
   parameter int unsigned BANK_W        = 32,
   parameter int unsigned SETTLE_CYCLES = 150,
   parameter int unsigned ADDR_W        = 8,
   parameter logic [ADDR_W-1:0] CTRL_OFFSET = 8'h94,
   parameter logic [ADDR_W-1:0] STRB_OFFSET = 8'h98
) (
   input logic                clk,
   input logic                rst_n,
   input logic                reg_wr,
   input logic [ADDR_W-1:0]   reg_addr,
   input logic [31:0]         reg_wdata,
   input logic                settle_busy,
   input logic                early_q,
   input logic [NUM_PINS-1:0] pull_up_en,
   input logic [NUM_PINS-1:0] pull_dn_en
);
   localparam int unsigned NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
   localparam int unsigned STRB_END  = STRB_OFFSET + 4 * NUM_BANKS;

   logic ctrl_wr, strb_wr, seen_q;
   int unsigned since_q;

   assign ctrl_wr = reg_wr && (reg_addr == CTRL_OFFSET);
   assign strb_wr = reg_wr && (int'(reg_addr) >= int'(STRB_OFFSET))
                    && (int'(reg_addr) < int'(STRB_END)) && (reg_addr[1:0] == 2'b00);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q  <= 1'b0;
         since_q <= 0;
      end else if (ctrl_wr) begin
         seen_q  <= 1'b1;
         since_q <= 1;
      end else if (since_q <= SETTLE_CYCLES) begin
         since_q <= since_q + 1;
      end
   end

   // R5: busy exactly while fewer than SETTLE_CYCLES+1 edges have passed
   a_r5_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
      settle_busy == (seen_q && since_q <= SETTLE_CYCLES));
   a_r5_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> settle_busy);
   // R6: strobe during settling latches the early flag
   a_r6_early_on_busy_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (strb_wr && settle_busy) |=> early_q);
   // R7: early flag only clears on a control write with bit 31
   a_r7_early_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (early_q && !(ctrl_wr && reg_wdata[31])) |=> early_q);
   // R3: outputs only move on a strobe write
   a_r3_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !strb_wr |=> ($stable(pull_up_en) && $stable(pull_dn_en)));
   // R2: a pin never drives both pulls
   a_r2_one_pull_per_pin: assert property (@(posedge clk) disable iff (!rst_n)
      (pull_up_en & pull_dn_en) == '0);
endmodule

bind pull_bias_sequencer pull_bias_sequencer_chk #(
   .NUM_PINS(NUM_PINS), .BANK_W(BANK_W), .SETTLE_CYCLES(SETTLE_CYCLES),
   .ADDR_W(ADDR_W), .CTRL_OFFSET(CTRL_OFFSET), .STRB_OFFSET(STRB_OFFSET)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr      (reg_wr),
   .reg_addr    (reg_addr),
   .reg_wdata   (reg_wdata),
   .settle_busy (settle_busy),
   .early_q     (early_q),
   .pull_up_en  (pull_up_en),
   .pull_dn_en  (pull_dn_en)
);

// File: tb/pull_bias_sequencer_test.sv
module pull_bias_sequencer_test;
   localparam int N      = 54;
   localparam int SETTLE = 150;
   localparam logic [7:0] CTRL = 8'h94;
   localparam logic [7:0] STB0 = 8'h98;
   localparam logic [7:0] STB1 = 8'h9C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = 8'h0;
   logic [31:0] reg_wdata = 32'h0;
   logic [31:0] reg_rdata;
   logic        settle_busy;
   logic [N-1:0] pull_up_en, pull_dn_en;

   int compared = 0;
   int mismatched = 0;
   bit done = 0;

   int st [N];
   int code_m, cnt_m, early_m;
   logic [31:0] stb_m [2];

   always #5 clk = ~clk;

   pull_bias_sequencer uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .settle_busy(settle_busy),
      .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en)
   );

   function automatic logic [31:0] exp_read(logic [7:0] a);
      logic [31:0] v = 32'h0;
      if (a == CTRL) begin
         v[1:0] = code_m[1:0];
         v[8]   = (cnt_m != 0);
         v[9]   = early_m[0];
      end else if (a == STB0) v = stb_m[0];
      else if (a == STB1) v = stb_m[1];
      return v;
   endfunction

   task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic check_now(string tag);
      logic [N-1:0] eu, ed;
      for (int i = 0; i < N; i++) begin
         eu[i] = (st[i] == 2);
         ed[i] = (st[i] == 1);
      end
      cmp(tag, "pull_up_en", 64'(pull_up_en), 64'(eu));
      cmp(tag, "pull_dn_en", 64'(pull_dn_en), 64'(ed));
      cmp(tag, "settle_busy", 64'(settle_busy), 64'(cnt_m != 0));
      cmp(tag, "reg_rdata", 64'(reg_rdata), 64'(exp_read(reg_addr)));
   endtask

   task automatic model_step(logic wr, logic [7:0] a, logic [31:0] d);
      bit busy_before = (cnt_m != 0);
      if (wr && a == CTRL) begin
         code_m = int'(d[1:0]);
         cnt_m  = SETTLE;
         if (d[31]) early_m = 0;
      end else begin
         if (cnt_m > 0) cnt_m--;
         if (wr && (a == STB0 || a == STB1)) begin
            int b = (a == STB1) ? 1 : 0;
            int live = b ? (N - 32) : 32;
            logic [31:0] nv = 32'h0;
            if (busy_before) early_m = 1;
            for (int j = 0; j < live; j++) begin
               nv[j] = d[j];
               if (d[j] && !stb_m[b][j] && code_m != 3) st[32*b + j] = code_m;
            end
            stb_m[b] = nv;
         end
      end
   endtask

   task automatic step(logic wr, logic [7:0] a, logic [31:0] d, string tag);
      check_now(tag);
      reg_wr = wr; reg_addr = a; reg_wdata = d;
      model_step(wr, a, d);
      @(negedge clk);
   endtask

   task automatic idle(int n, logic [7:0] a, string tag);
      for (int k = 0; k < n; k++) step(1'b0, a, 32'h0, tag);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog (R1..R11 run hung): actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) st[i] = 0;
      code_m = 0; cnt_m = 0; early_m = 0; stb_m[0] = 0; stb_m[1] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R8: reset state, read back control and both strobe registers
      idle(2, CTRL, "R8 reset ctrl");
      idle(1, STB0, "R8 reset strobe0");
      idle(1, STB1, "R8 reset strobe1");

      // R5: busy window after a pull-down code load
      step(1'b1, CTRL, 32'h1, "R1 load down");
      idle(SETTLE + 5, CTRL, "R5 settle window");
      // R2: capture on rising strobe bits 0 and 5
      step(1'b1, STB0, 32'h21, "R2 strobe pins 0,5");
      idle(2, STB0, "R2 captured");
      // R3: strobe back to zero, pins hold
      step(1'b1, STB0, 32'h0, "R3 strobe clear");
      idle(3, CTRL, "R3 hold");

      // R9: pull-up into bank 1 with junk above pin 53
      step(1'b1, CTRL, 32'h2, "R1 load up");
      idle(SETTLE + 2, CTRL, "R5 second window");
      step(1'b1, STB1, 32'h8020_0001, "R9 strobe bank1");
      idle(2, STB1, "R9 readback bank1");

      // R10: code changes, same strobe rewritten, no capture
      step(1'b1, CTRL, 32'h0, "R1 load none");
      idle(SETTLE + 2, CTRL, "R5 third window");
      step(1'b1, STB1, 32'h0020_0001, "R10 rewrite set bits");
      idle(2, STB1, "R10 no recapture");
      step(1'b1, STB1, 32'h0, "R3 clear bank1");
      step(1'b1, STB1, 32'h1, "R2 pin 32 to none");
      idle(2, STB1, "R2 pin 32 result");
      step(1'b1, STB1, 32'h0, "R3 clear bank1 again");

      // R4: reserved code, strobe every bank0 pin
      step(1'b1, CTRL, 32'h3, "R4 load reserved");
      idle(SETTLE + 2, CTRL, "R4 readback code 3");
      step(1'b1, STB0, 32'hFFFF_FFFF, "R4 strobe all bank0");
      idle(2, STB0, "R4 no change");
      step(1'b1, STB0, 32'h0, "R3 clear bank0");

      // R6: strobe while busy still captures, sets early flag
      step(1'b1, CTRL, 32'h2, "R6 load up");
      step(1'b1, STB0, 32'h80, "R6 early strobe");
      idle(5, CTRL, "R6 early flag set");
      // R7: bit 31 clear keeps the flag; R1 upper bits ignored
      step(1'b1, CTRL, 32'h7FFF_FF06, "R1 R7 upper bits");
      idle(3, CTRL, "R7 flag kept");
      step(1'b1, CTRL, 32'h8000_0000, "R7 clear flag");
      idle(SETTLE + 3, CTRL, "R7 flag cleared");

      // R11: other offsets read zero
      idle(1, 8'h90, "R11 below map");
      idle(1, 8'hA0, "R11 above map");
      idle(1, 8'h00, "R11 offset zero");
      check_now("R11 final");

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule